// File: doc/BRIEF.md
# Serial Lane Power-Up Sequencer

The block brings one serial transceiver lane from its power-down state to carrying data. A single-cycle start pulse carries the interface request, the reference-clock strap, and the loopback and polarity options. On that pulse the block derives and latches the lane and PLL configuration words. It then walks the analog macro through a fixed chain of enables and reset releases, with millisecond dwell times between them. At four checkpoints it samples the macro's status inputs. It ends either with the data paths enabled and `done` raised, or with `err` raised and a code that names the checkpoint that failed.

All dwell times come from one down-counter whose clocks-per-millisecond value is a parameter. A fast simulation therefore uses a small value and silicon uses the real clock rate. When a checkpoint fails, the sequence halts and leaves every output it has already driven where it is. A new start pulse is accepted only from idle, done or error, and it restarts the whole chain from the power-down state.

Top module: `lane_bringup_seq`

## Requirements
- R1: After synchronous reset, the reset outputs `lane_rx_rst`, `lane_tx_rst` and `phy_rst` are 1. Every enable, `busy`, `done` and `err` is 0, `err_code` is 0, and every configuration output is 0.
- R2: `iface` is encoded 0 QSGMII, 1 SGMII, 2 1000BASE-X, 3 2500BASE-X. For QSGMII, `lane_10b`=0 and both rate codes are 0. With a 125 MHz reference, `mpll_mult`=40 and `ref_div2`=1; otherwise `mpll_mult`=100 and `ref_div2`=0.
- R3: SGMII and 1000BASE-X run at 1G. They give `lane_10b`=1 and both rate codes 2. `mpll_mult` is 40 with a 125 MHz reference and 100 otherwise, and `ref_div2` is 1 only with a 125 MHz reference.
- R4: 2500BASE-X runs at 2.5G. It gives `lane_10b`=1 and both rate codes 1. `mpll_mult` is 50 with a 125 MHz reference and 125 otherwise, and `ref_div2` is 1 only with a 125 MHz reference.
- R5: The reference is taken as 125 MHz exactly when `clk_strap` is 1 or 2. The value 0 (25 MHz) and the value 3 (bypass) both select the non-125 settings.
- R6: `loopbk_en`, `tx_inv` and `rx_inv` copy the latched loopback and polarity requests, and `rx_term_en` is always 0. The configuration is latched on the accepted start edge and holds until the next accepted start, whatever the inputs do in between.
- R7: K is CLK_PER_MS and edge 0 is the edge that accepts start. The lane resets drop after edge 0 and `ref_clk_en` rises after edge 2. `phy_rst` drops after edge 2+K, and `mpll_en` rises after edge 2+2K. `busy` is 1 from edge 0 until the sequence stops.
- R8: At edge 2+9K, `mpll_ok`=1 raises `txcm_en`. `mpll_ok`=0 stops the sequence with `err`=1 and `err_code`=1, and every other output holds its value.
- R9: At edge 2+10K, `txcm_ok`=1 raises `rxpll_en` and `tx_en` together. `txcm_ok`=0 stops the sequence with `err_code`=2.
- R10: At edge 2+11K, `rxpll_ok`=0 stops the sequence with `err_code`=3, whatever `tx_ok` is. Otherwise `tx_ok`=0 stops it with `err_code`=4.
- R11: If both inputs pass at edge 2+11K, `tx_data_en`, `rx_data_en` and `done` rise together and `busy` falls. Status inputs have no effect outside their own checkpoint edge.
- R12: A start pulse while `busy` is 1 has no effect on any output.
- R13: A start accepted from done or error first returns every control output to its power-down value and clears `done`, `err` and `err_code`. It then runs the full sequence with the new configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start pulse, accepted when not busy |
| iface | input | 2 | Interface request (0 QSGMII, 1 SGMII, 2 1000BASE-X, 3 2500BASE-X) |
| clk_strap | input | 2 | Reference-clock strap field |
| loopback_req | input | 1 | Request TX-to-RX loopback |
| tx_inv_req | input | 1 | Request TX polarity inversion |
| rx_inv_req | input | 1 | Request RX polarity inversion |
| mpll_ok | input | 1 | Main PLL state from macro |
| txcm_ok | input | 1 | TX common-mode state from macro |
| rxpll_ok | input | 1 | RX PLL state from macro |
| tx_ok | input | 1 | Transmitter state from macro |
| lane_10b | output | 1 | 10-bit lane width select |
| tx_rate | output | 2 | TX rate code |
| rx_rate | output | 2 | RX rate code |
| mpll_mult | output | 7 | Main PLL multiplier |
| ref_div2 | output | 1 | Reference divide-by-2 |
| loopbk_en | output | 1 | Lane loopback enable |
| tx_inv | output | 1 | TX inversion |
| rx_inv | output | 1 | RX inversion |
| rx_term_en | output | 1 | Receiver termination enable (held 0) |
| lane_rx_rst | output | 1 | Lane RX reset |
| lane_tx_rst | output | 1 | Lane TX reset |
| ref_clk_en | output | 1 | Reference clock enable |
| phy_rst | output | 1 | PHY reset |
| mpll_en | output | 1 | Main PLL enable |
| txcm_en | output | 1 | TX common-mode enable |
| rxpll_en | output | 1 | RX PLL enable |
| tx_en | output | 1 | Transmitter enable |
| tx_data_en | output | 1 | TX data enable |
| rx_data_en | output | 1 | RX data enable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence completed |
| err | output | 1 | Sequence stopped on a failed checkpoint |
| err_code | output | 3 | Failed checkpoint (0 none, 1 main PLL, 2 common mode, 3 RX PLL, 4 TX) |

## Verification
The bench compares every control output on every cycle of each run against a cycle-indexed model. A dwell off by one cycle, or a step taken out of order, therefore shows up at the exact edge where it happens. Status inputs carry random values everywhere except at their own checkpoint edge. A design that sampled them early or late would stop by mistake, or run past a forced failure.

At the last checkpoint both the RX PLL and the TX inputs are sometimes failing together. A design with the priority reversed would report code 4 where code 3 is expected. Configuration inputs are scrambled during each run and a second start is pulsed mid-sequence. A design that failed to latch, or that let a start through while busy, would change its configuration words or restart its timeline. The strap sweep covers the bypass and 25 MHz values, so a decoder that treated any nonzero strap as 125 MHz would produce the wrong multiplier.

// File: rtl/lane_bringup_pkg.sv
package lane_bringup_pkg;

   localparam int MULT_W = 7;
   localparam int RATE_W = 2;
   localparam int CODE_W = 3;

   typedef enum logic [1:0] {
      IF_QSGMII = 2'd0,
      IF_SGMII  = 2'd1,
      IF_1000X  = 2'd2,
      IF_2500X  = 2'd3
   } iface_e;

   typedef enum logic [CODE_W-1:0] {
      FAIL_NONE  = 3'd0,
      FAIL_MPLL  = 3'd1,
      FAIL_TXCM  = 3'd2,
      FAIL_RXPLL = 3'd3,
      FAIL_TX    = 3'd4
   } fail_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_TERM,
      ST_REF,
      ST_W_PHY,
      ST_W_PLLEN,
      ST_W_PLLCHK,
      ST_W_CMCHK,
      ST_W_LASTCHK,
      ST_DONE,
      ST_STOP
   } seq_st_e;

   typedef struct packed {
      logic              ten_bit;
      logic [RATE_W-1:0] tx_rate;
      logic [RATE_W-1:0] rx_rate;
      logic [MULT_W-1:0] mult;
      logic              div2;
      logic              loopbk;
      logic              tx_inv;
      logic              rx_inv;
   } lane_cfg_t;

endpackage

// File: rtl/lane_cfg_map.sv
module lane_cfg_map
   import lane_bringup_pkg::*;
(
   input  logic [1:0] iface,
   input  logic [1:0] clk_strap,
   input  logic       loopback_req,
   input  logic       tx_inv_req,
   input  logic       rx_inv_req,
   output lane_cfg_t  cfg
);

   logic   ref125;
   iface_e ifc;

   assign ifc    = iface_e'(iface);
   assign ref125 = (clk_strap == 2'd1) || (clk_strap == 2'd2);

   always_comb begin
      cfg        = '0;
      cfg.div2   = ref125;
      cfg.loopbk = loopback_req;
      cfg.tx_inv = tx_inv_req;
      cfg.rx_inv = rx_inv_req;
      case (ifc)
         IF_QSGMII: begin
            cfg.ten_bit = 1'b0;
            cfg.tx_rate = 2'd0;
            cfg.rx_rate = 2'd0;
            cfg.mult    = ref125 ? MULT_W'(40) : MULT_W'(100);
         end
         IF_2500X: begin
            cfg.ten_bit = 1'b1;
            cfg.tx_rate = 2'd1;
            cfg.rx_rate = 2'd1;
            cfg.mult    = ref125 ? MULT_W'(50) : MULT_W'(125);
         end
         default: begin
            cfg.ten_bit = 1'b1;
            cfg.tx_rate = 2'd2;
            cfg.rx_rate = 2'd2;
            cfg.mult    = ref125 ? MULT_W'(40) : MULT_W'(100);
         end
      endcase
   end

endmodule

// File: rtl/lane_dwell_timer.sv
module lane_dwell_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - CNT_W'(1);
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/lane_seq_fsm.sv
module lane_seq_fsm
   import lane_bringup_pkg::*;
#(
   parameter int CNT_W    = 4,
   parameter int STEP_CYC = 1,
   parameter int PLL_CYC  = 7
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic              mpll_ok,
   input  logic              txcm_ok,
   input  logic              rxpll_ok,
   input  logic              tx_ok,
   input  logic              tmr_expired,
   output logic              tmr_load,
   output logic [CNT_W-1:0]  tmr_val,
   output logic              accept,
   output logic              lane_rst,
   output logic              ref_clk_en,
   output logic              phy_rst,
   output logic              mpll_en,
   output logic              txcm_en,
   output logic              rxrun_en,
   output logic              data_en,
   output logic              busy,
   output logic              done,
   output logic [CODE_W-1:0] err_code
);

   seq_st_e st;

   assign busy   = !(st == ST_IDLE || st == ST_DONE || st == ST_STOP);
   assign accept = start && !busy;

   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = CNT_W'(STEP_CYC - 1);
      case (st)
         ST_REF:      tmr_load = 1'b1;
         ST_W_PHY:    tmr_load = tmr_expired;
         ST_W_PLLEN: begin
            tmr_load = tmr_expired;
            tmr_val  = CNT_W'(PLL_CYC - 1);
         end
         ST_W_PLLCHK: tmr_load = tmr_expired;
         ST_W_CMCHK:  tmr_load = tmr_expired;
         default:     tmr_load = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st         <= ST_IDLE;
         lane_rst   <= 1'b1;
         ref_clk_en <= 1'b0;
         phy_rst    <= 1'b1;
         mpll_en    <= 1'b0;
         txcm_en    <= 1'b0;
         rxrun_en   <= 1'b0;
         data_en    <= 1'b0;
         done       <= 1'b0;
         err_code   <= FAIL_NONE;
      end else begin
         case (st)
            ST_IDLE, ST_DONE, ST_STOP: begin
               if (start) begin
                  st         <= ST_TERM;
                  lane_rst   <= 1'b0;
                  ref_clk_en <= 1'b0;
                  phy_rst    <= 1'b1;
                  mpll_en    <= 1'b0;
                  txcm_en    <= 1'b0;
                  rxrun_en   <= 1'b0;
                  data_en    <= 1'b0;
                  done       <= 1'b0;
                  err_code   <= FAIL_NONE;
               end
            end
            ST_TERM: st <= ST_REF;
            ST_REF: begin
               ref_clk_en <= 1'b1;
               st         <= ST_W_PHY;
            end
            ST_W_PHY: if (tmr_expired) begin
               phy_rst <= 1'b0;
               st      <= ST_W_PLLEN;
            end
            ST_W_PLLEN: if (tmr_expired) begin
               mpll_en <= 1'b1;
               st      <= ST_W_PLLCHK;
            end
            ST_W_PLLCHK: if (tmr_expired) begin
               if (mpll_ok) begin
                  txcm_en <= 1'b1;
                  st      <= ST_W_CMCHK;
               end else begin
                  err_code <= FAIL_MPLL;
                  st       <= ST_STOP;
               end
            end
            ST_W_CMCHK: if (tmr_expired) begin
               if (txcm_ok) begin
                  rxrun_en <= 1'b1;
                  st       <= ST_W_LASTCHK;
               end else begin
                  err_code <= FAIL_TXCM;
                  st       <= ST_STOP;
               end
            end
            ST_W_LASTCHK: if (tmr_expired) begin
               if (!rxpll_ok) begin
                  err_code <= FAIL_RXPLL;
                  st       <= ST_STOP;
               end else if (!tx_ok) begin
                  err_code <= FAIL_TX;
                  st       <= ST_STOP;
               end else begin
                  data_en <= 1'b1;
                  done    <= 1'b1;
                  st      <= ST_DONE;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/lane_bringup_seq.sv
module lane_bringup_seq
   import lane_bringup_pkg::*;
#(
   parameter int CLK_PER_MS = 100000,
   parameter int STEP_MS    = 1,
   parameter int PLL_MS     = 7
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [1:0]        iface,
   input  logic [1:0]        clk_strap,
   input  logic              loopback_req,
   input  logic              tx_inv_req,
   input  logic              rx_inv_req,
   input  logic              mpll_ok,
   input  logic              txcm_ok,
   input  logic              rxpll_ok,
   input  logic              tx_ok,
   output logic              lane_10b,
   output logic [RATE_W-1:0] tx_rate,
   output logic [RATE_W-1:0] rx_rate,
   output logic [MULT_W-1:0] mpll_mult,
   output logic              ref_div2,
   output logic              loopbk_en,
   output logic              tx_inv,
   output logic              rx_inv,
   output logic              rx_term_en,
   output logic              lane_rx_rst,
   output logic              lane_tx_rst,
   output logic              ref_clk_en,
   output logic              phy_rst,
   output logic              mpll_en,
   output logic              txcm_en,
   output logic              rxpll_en,
   output logic              tx_en,
   output logic              tx_data_en,
   output logic              rx_data_en,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [CODE_W-1:0] err_code
);

   localparam int STEP_CYC = STEP_MS * CLK_PER_MS;
   localparam int PLL_CYC  = PLL_MS * CLK_PER_MS;
   localparam int MAX_CYC  = (PLL_CYC > STEP_CYC) ? PLL_CYC : STEP_CYC;
   localparam int CNT_W    = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

   if (CLK_PER_MS < 1) begin : g_bad_rate
      $error("CLK_PER_MS must be at least 1");
   end
   if (STEP_MS < 1 || PLL_MS < 1) begin : g_bad_dwell
      $error("dwell lengths must be at least 1 ms");
   end

   lane_cfg_t        cfg_d;
   lane_cfg_t        cfg_q;
   logic             accept;
   logic             tmr_load;
   logic             tmr_expired;
   logic [CNT_W-1:0] tmr_val;
   logic             lane_rst;
   logic             rxrun_en;
   logic             data_en;

   lane_cfg_map u_map (
      .iface        (iface),
      .clk_strap    (clk_strap),
      .loopback_req (loopback_req),
      .tx_inv_req   (tx_inv_req),
      .rx_inv_req   (rx_inv_req),
      .cfg          (cfg_d)
   );

   always_ff @(posedge clk) begin
      if (rst)
         cfg_q <= '0;
      else if (accept)
         cfg_q <= cfg_d;
   end

   lane_dwell_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   lane_seq_fsm #(
      .CNT_W    (CNT_W),
      .STEP_CYC (STEP_CYC),
      .PLL_CYC  (PLL_CYC)
   ) u_fsm (
      .clk         (clk),
      .rst         (rst),
      .start       (start),
      .mpll_ok     (mpll_ok),
      .txcm_ok     (txcm_ok),
      .rxpll_ok    (rxpll_ok),
      .tx_ok       (tx_ok),
      .tmr_expired (tmr_expired),
      .tmr_load    (tmr_load),
      .tmr_val     (tmr_val),
      .accept      (accept),
      .lane_rst    (lane_rst),
      .ref_clk_en  (ref_clk_en),
      .phy_rst     (phy_rst),
      .mpll_en     (mpll_en),
      .txcm_en     (txcm_en),
      .rxrun_en    (rxrun_en),
      .data_en     (data_en),
      .busy        (busy),
      .done        (done),
      .err_code    (err_code)
   );

   assign lane_10b    = cfg_q.ten_bit;
   assign tx_rate     = cfg_q.tx_rate;
   assign rx_rate     = cfg_q.rx_rate;
   assign mpll_mult   = cfg_q.mult;
   assign ref_div2    = cfg_q.div2;
   assign loopbk_en   = cfg_q.loopbk;
   assign tx_inv      = cfg_q.tx_inv;
   assign rx_inv      = cfg_q.rx_inv;
   assign rx_term_en  = 1'b0;
   assign lane_rx_rst = lane_rst;
   assign lane_tx_rst = lane_rst;
   assign rxpll_en    = rxrun_en;
   assign tx_en       = rxrun_en;
   assign tx_data_en  = data_en;
   assign rx_data_en  = data_en;
   assign err         = (err_code != '0);

endmodule

// File: rtl/lane_bringup_chk.sv
module lane_bringup_chk (
   input logic       clk,
   input logic       rst,
   input logic       mpll_ok,
   input logic       txcm_ok,
   input logic       rxpll_ok,
   input logic       tx_ok,
   input logic       lane_10b,
   input logic [1:0] tx_rate,
   input logic [6:0] mpll_mult,
   input logic       ref_clk_en,
   input logic       phy_rst,
   input logic       mpll_en,
   input logic       txcm_en,
   input logic       rxpll_en,
   input logic       tx_en,
   input logic       tx_data_en,
   input logic       rx_data_en,
   input logic       busy,
   input logic       done,
   input logic       err,
   input logic [2:0] err_code
);

   AST_PHY_AFTER_REF: assert property (@(posedge clk) disable iff (rst)
      !phy_rst |-> ref_clk_en); // R7
   AST_PLL_AFTER_PHY: assert property (@(posedge clk) disable iff (rst)
      mpll_en |-> !phy_rst); // R7
   AST_CM_NEEDS_MPLL: assert property (@(posedge clk) disable iff (rst)
      $rose(txcm_en) |-> $past(mpll_ok)); // R8
   AST_ERR_HALTS: assert property (@(posedge clk) disable iff (rst)
      err |-> (!busy && !done)); // R8
   AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (err && $past(err)) |-> ($stable(err_code) && $stable(txcm_en) && $stable(mpll_en))); // R8
   AST_RUN_NEEDS_CM: assert property (@(posedge clk) disable iff (rst)
      $rose(tx_en) |-> ($past(txcm_ok) && rxpll_en && txcm_en)); // R9
   AST_DATA_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
      $rose(tx_data_en) |-> ($past(rxpll_ok) && $past(tx_ok))); // R10
   AST_DONE_DATA: assert property (@(posedge clk) disable iff (rst)
      done |-> (tx_data_en && rx_data_en && !err)); // R11
   AST_CFG_LATCHED: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy)) |-> ($stable(mpll_mult) && $stable(tx_rate) && $stable(lane_10b))); // R12

endmodule

bind lane_bringup_seq lane_bringup_chk u_chk (
   .clk        (clk),
   .rst        (rst),
   .mpll_ok    (mpll_ok),
   .txcm_ok    (txcm_ok),
   .rxpll_ok   (rxpll_ok),
   .tx_ok      (tx_ok),
   .lane_10b   (lane_10b),
   .tx_rate    (tx_rate),
   .mpll_mult  (mpll_mult),
   .ref_clk_en (ref_clk_en),
   .phy_rst    (phy_rst),
   .mpll_en    (mpll_en),
   .txcm_en    (txcm_en),
   .rxpll_en   (rxpll_en),
   .tx_en      (tx_en),
   .tx_data_en (tx_data_en),
   .rx_data_en (rx_data_en),
   .busy       (busy),
   .done       (done),
   .err        (err),
   .err_code   (err_code)
);

// File: tb/lane_bringup_seq_tb.sv
module lane_bringup_seq_tb;

   localparam int K  = 4;
   localparam int C1 = 2 + 9 * K;
   localparam int C2 = 2 + 10 * K;
   localparam int C3 = 2 + 11 * K;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start = 1'b0;
   logic [1:0] iface = 2'd0;
   logic [1:0] clk_strap = 2'd0;
   logic       loopback_req = 1'b0;
   logic       tx_inv_req = 1'b0;
   logic       rx_inv_req = 1'b0;
   logic       mpll_ok = 1'b0;
   logic       txcm_ok = 1'b0;
   logic       rxpll_ok = 1'b0;
   logic       tx_ok = 1'b0;
   logic       lane_10b, ref_div2, loopbk_en, tx_inv, rx_inv, rx_term_en;
   logic [1:0] tx_rate, rx_rate;
   logic [6:0] mpll_mult;
   logic       lane_rx_rst, lane_tx_rst, ref_clk_en, phy_rst, mpll_en, txcm_en;
   logic       rxpll_en, tx_en, tx_data_en, rx_data_en, busy, done, err;
   logic [2:0] err_code;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   lane_bringup_seq #(.CLK_PER_MS(K)) u_dut (
      .clk(clk), .rst(rst), .start(start), .iface(iface), .clk_strap(clk_strap),
      .loopback_req(loopback_req), .tx_inv_req(tx_inv_req), .rx_inv_req(rx_inv_req),
      .mpll_ok(mpll_ok), .txcm_ok(txcm_ok), .rxpll_ok(rxpll_ok), .tx_ok(tx_ok),
      .lane_10b(lane_10b), .tx_rate(tx_rate), .rx_rate(rx_rate), .mpll_mult(mpll_mult),
      .ref_div2(ref_div2), .loopbk_en(loopbk_en), .tx_inv(tx_inv), .rx_inv(rx_inv),
      .rx_term_en(rx_term_en), .lane_rx_rst(lane_rx_rst), .lane_tx_rst(lane_tx_rst),
      .ref_clk_en(ref_clk_en), .phy_rst(phy_rst), .mpll_en(mpll_en), .txcm_en(txcm_en),
      .rxpll_en(rxpll_en), .tx_en(tx_en), .tx_data_en(tx_data_en), .rx_data_en(rx_data_en),
      .busy(busy), .done(done), .err(err), .err_code(err_code)
   );

   function automatic logic [16:0] exp_cfg(logic [1:0] ifc, logic [1:0] strap,
                                           logic lb, logic ti, logic ri);
      logic       r125;
      logic       tb;
      logic [1:0] rate;
      logic [6:0] mult;
      r125 = (strap == 2'd1) || (strap == 2'd2);
      if (ifc == 2'd0) begin
         tb = 1'b0; rate = 2'd0; mult = r125 ? 7'd40 : 7'd100;
      end else if (ifc == 2'd3) begin
         tb = 1'b1; rate = 2'd1; mult = r125 ? 7'd50 : 7'd125;
      end else begin
         tb = 1'b1; rate = 2'd2; mult = r125 ? 7'd40 : 7'd100;
      end
      return {tb, rate, rate, mult, r125, lb, ti, ri, 1'b0};
   endfunction

   function automatic int stop_edge(int f);
      if (f == 1) return C1;
      if (f == 2) return C2;
      return C3;
   endfunction

   function automatic logic [15:0] exp_ctl(int n, int f);
      logic b, rf, pr, me, ce, re, de, dn, er;
      logic [2:0] code;
      int fe;
      fe   = stop_edge(f);
      b    = (n < fe);
      rf   = (n >= 2);
      pr   = !(n >= 2 + K);
      me   = (n >= 2 + 2 * K);
      ce   = (n >= C1) && (f != 1);
      re   = (n >= C2) && (f != 1) && (f != 2);
      de   = (n >= C3) && (f == 0);
      dn   = de;
      er   = (f != 0) && (n >= fe);
      code = er ? 3'(f) : 3'd0;
      return {1'b0, 1'b0, rf, pr, me, ce, re, re, de, de, b, dn, er, code};
   endfunction

   function automatic logic [15:0] act_ctl();
      return {lane_rx_rst, lane_tx_rst, ref_clk_en, phy_rst, mpll_en, txcm_en,
              rxpll_en, tx_en, tx_data_en, rx_data_en, busy, done, err, err_code};
   endfunction

   function automatic logic [16:0] act_cfg();
      return {lane_10b, tx_rate, rx_rate, mpll_mult, ref_div2, loopbk_en,
              tx_inv, rx_inv, rx_term_en};
   endfunction

   task automatic check(string tag, int n, logic [16:0] act, logic [16:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s cycle=%0d actual=%h expected=%h", tag, n, act, exp);
      end
   endtask

   task automatic run_case(logic [1:0] ifc, logic [1:0] strap, logic lb,
                           logic ti, logic ri, int f);
      logic [16:0] ecfg;
      string ctag, ftag;
      int fe;
      fe = stop_edge(f);
      ecfg = exp_cfg(ifc, strap, lb, ti, ri);
      ctag = (ifc == 2'd0) ? "R2 R5 R6" : (ifc == 2'd3) ? "R4 R5 R6" : "R3 R5 R6";
      @(negedge clk);
      iface = ifc; clk_strap = strap; loopback_req = lb;
      tx_inv_req = ti; rx_inv_req = ri; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int n = 0; n <= fe + 2; n++) begin
         if (n == 0) ftag = "R13";
         else if (n == 6) ftag = "R12";
         else if (f == 1 && n >= C1) ftag = "R8";
         else if (f == 2 && n >= C2) ftag = "R9";
         else if (f >= 3 && n >= C3) ftag = "R10";
         else if (f == 0 && n >= C3) ftag = "R11";
         else ftag = "R7";
         check(ftag, n, {1'b0, act_ctl()}, {1'b0, exp_ctl(n, f)});
         check(ctag, n, act_cfg(), ecfg);
         mpll_ok  = (n + 1 == C1) ? (f != 1) : 1'($urandom);
         txcm_ok  = (n + 1 == C2) ? (f != 2) : 1'($urandom);
         rxpll_ok = (n + 1 == C3) ? (f != 3) : 1'($urandom);
         if (n + 1 == C3)
            tx_ok = (f == 4) ? 1'b0 : (f == 3) ? 1'($urandom) : 1'b1;
         else
            tx_ok = 1'($urandom);
         iface = 2'($urandom); clk_strap = 2'($urandom);
         loopback_req = 1'($urandom); tx_inv_req = 1'($urandom);
         rx_inv_req = 1'($urandom);
         start = (n == 5);
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL R7 watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      check("R1", 0, {1'b0, act_ctl()}, {1'b0, 16'b1101_0000_0000_0000});
      check("R1", 0, act_cfg(), 17'd0);
      for (int s = 0; s < 4; s++)
         for (int i = 0; i < 4; i++)
            run_case(2'(i), 2'(s), 1'(i), 1'(s), 1'(i + s), 0);
      run_case(2'd0, 2'd1, 1'b1, 1'b0, 1'b1, 1);
      run_case(2'd1, 2'd3, 1'b0, 1'b1, 1'b0, 2);
      run_case(2'd3, 2'd2, 1'b1, 1'b1, 1'b1, 3);
      run_case(2'd2, 2'd0, 1'b0, 1'b0, 1'b1, 4);
      for (int r = 0; r < 12; r++)
         run_case(2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), int'($urandom % 5));
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule